// File: doc/BRIEF.md
# Latched Three-Bit Line Decoder

This block turns a three-bit select code into one of eight active-low output lines. A capture register sits in front of the decode stage. It is controlled by a hold input. While the hold input is low, the register loads the select code on every clock, and the outputs follow the live select bits with no added delay. While the hold input is high, the register keeps the code it last loaded, and the outputs decode that stored code. Changes on the select bits have no effect during that time.

Two gating inputs act on the output stage only. One is active low and the other is active high. The outputs decode only when both are in their active state. Otherwise all eight lines sit high. The capture register keeps working whatever the gating inputs do, so turning the gates back on shows the code held at that moment. A typical use is selecting one of eight devices from an address that has to stay frozen while the bus moves on.

Top module: `ldec8_top`

## Requirements
- R1: When enabled, exactly one output is low: the line whose index equals the decoded code, formed as {sel_hi, sel_mid, sel_lo} with sel_lo as the least significant bit. All other lines are high.
- R2: When gate_n is 1 or gate is 0, all eight outputs are 1.
- R3: While hold is 0, the outputs decode the live select inputs in the same cycle, with no register delay.
- R4: While hold is 1, the outputs decode the code sampled at the last clock edge at which hold was still 0. Changes on the select inputs have no effect.
- R5: The gating inputs do not change the stored code. If the outputs are disabled and re-enabled while hold stays 1, they show the stored code.
- R6: A synchronous reset (rst_n low at a clock edge) clears the stored code to 0. Holding right after reset therefore selects line 0.
- R7: Code 0 drives y_n[0] low and code 7 drives y_n[7] low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_lo | input | 1 | Select bit 0 (LSB) |
| sel_mid | input | 1 | Select bit 1 |
| sel_hi | input | 1 | Select bit 2 (MSB) |
| hold | input | 1 | 0: register transparent; 1: keep stored code |
| gate_n | input | 1 | Active-low output enable |
| gate | input | 1 | Active-high output enable |
| y_n | output | 8 | Active-low decoded lines, index = code |

## Verification
The bench targets the hand-over from transparent to hold. It checks that the code frozen is the one from the last cycle with hold low. A design that captured one cycle late would show the newer code, and a design that ignored hold would track the select bits.

It also disables the outputs, changes both hold and the select bits, then re-enables. A design that stopped the register while gated would show a stale code.

The full table of eight codes under all four gate combinations catches swapped polarities and reversed bit order. A reversed order would light line 4 for code 1.

// File: rtl/ldec8_pkg.sv
package ldec8_pkg;
    localparam int unsigned SEL_W = 3;
    localparam int unsigned LINES = 1 << SEL_W;
    typedef logic [SEL_W-1:0] code_t;
    typedef logic [LINES-1:0] lines_t;
endpackage

// File: rtl/ldec8_latch.sv
// Capture register modelling the address latch.
// Assumes: hold is synchronous to clk; reset is synchronous, active low.
// Output 'code' is the live input while hold=0, else the stored value.
module ldec8_latch
    import ldec8_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t sel,
    input  logic  hold,
    output code_t code,
    output code_t stored
);
    code_t q;

    // Load every cycle while transparent, keep while holding.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!hold)
            q <= sel;
    end

    // Transparent path bypasses the register so there is no added delay.
    always_comb code = hold ? q : sel;

    assign stored = q;
endmodule

// File: rtl/ldec8_decode.sv
// Binary to active-low one-cold decoder with a combined enable.
// Assumes: en already combines both polarity gates.
module ldec8_decode
    import ldec8_pkg::*;
(
    input  code_t  code,
    input  logic   en,
    output lines_t y_n
);
    // One line per minterm; each goes low only for its own index.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign y_n[i] = !(en && (code == code_t'(i)));
    end
endmodule

// File: rtl/ldec8_top.sv
// Latched 3-to-8 decoder with mixed-polarity output gates.
// Assumes: single clock; gates affect only the output stage.
module ldec8_top
    import ldec8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_lo,
    input  logic       sel_mid,
    input  logic       sel_hi,
    input  logic       hold,
    input  logic       gate_n,
    input  logic       gate,
    output logic [7:0] y_n
);
    code_t  sel;
    code_t  code;
    code_t  stored;
    logic   en;
    lines_t lines;

    // Assemble select code, MSB first.
    assign sel = {sel_hi, sel_mid, sel_lo};

    // Both gates must be active to decode.
    assign en = !gate_n && gate;

    ldec8_latch u_latch (
        .clk(clk), .rst_n(rst_n), .sel(sel), .hold(hold),
        .code(code), .stored(stored)
    );

    ldec8_decode u_dec (.code(code), .en(en), .y_n(lines));

    assign y_n = lines;
endmodule

// File: rtl/ldec8_check.sv
// Property checker bound to ldec8_top.
module ldec8_check (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_lo,
    input logic       sel_mid,
    input logic       sel_hi,
    input logic       hold,
    input logic       gate_n,
    input logic       gate,
    input logic [7:0] y_n
);
    // R2: disabled -> all high
    a_r2_disabled_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_n || !gate) |-> (y_n == 8'hFF));

    // R1: enabled -> exactly one low
    a_r1_one_cold: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_n && gate) |-> ($countones(~y_n) == 1));

    // R1/R3: transparent and enabled -> line of live code low
    a_r3_follow_live: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !gate_n && gate) |-> (y_n[{sel_hi, sel_mid, sel_lo}] == 1'b0));

    // R4: holding with stable gates -> outputs stable
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold) && $stable(gate_n) && $stable(gate)) |-> $stable(y_n));
endmodule

bind ldec8_top ldec8_check u_check (
    .clk(clk), .rst_n(rst_n), .sel_lo(sel_lo), .sel_mid(sel_mid),
    .sel_hi(sel_hi), .hold(hold), .gate_n(gate_n), .gate(gate), .y_n(y_n)
);

// File: tb/ldec8_top_test.sv
module ldec8_top_test;
    localparam int CLK_PERIOD = 10;
    // vector: {hold(1), gate_n(1), gate(1), code(3)}; all applied with hold=0
    localparam int NV = 32;
    localparam logic [5:0] VEC [NV] = '{
        6'o00,6'o01,6'o02,6'o03,6'o04,6'o05,6'o06,6'o07,
        6'o10,6'o11,6'o12,6'o13,6'o14,6'o15,6'o16,6'o17,
        6'o20,6'o21,6'o22,6'o23,6'o24,6'o25,6'o26,6'o27,
        6'o30,6'o31,6'o32,6'o33,6'o34,6'o35,6'o36,6'o37};

    logic clk = 0, rst_n = 0;
    logic sel_lo = 0, sel_mid = 0, sel_hi = 0, hold = 0, gate_n = 1, gate = 0;
    logic [7:0] y_n;
    int checks = 0, fails = 0;
    bit done = 0;

    ldec8_top uut (.clk(clk), .rst_n(rst_n), .sel_lo(sel_lo), .sel_mid(sel_mid),
        .sel_hi(sel_hi), .hold(hold), .gate_n(gate_n), .gate(gate), .y_n(y_n));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model(input logic [2:0] c, input logic gn, input logic g);
        return (!gn && g) ? ~(8'd1 << c) : 8'hFF;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (y_n !== exp) begin
            fails++;
            $display("FAIL %s: y_n=%b expected %b", req, y_n, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c);
        {sel_hi, sel_mid, sel_lo} = c;
    endtask

    // Step to just after the next rising edge, then settle.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++; checks++;
        $display("FAIL watchdog: expired, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1; #1;
        check("R2 reset state disabled", 8'hFF);
        // Table walk: R1 R2 R3 R7, transparent mode, combinational response.
        for (int i = 0; i < NV; i++) begin
            hold = 0; gate_n = VEC[i][4]; gate = VEC[i][3]; drive(VEC[i][2:0]);
            #1;
            check("R1/R2/R3 table", model(VEC[i][2:0], VEC[i][4], VEC[i][3]));
            tick();
        end
        gate_n = 0; gate = 1;
        // R7: code endpoints
        drive(3'd0); #1; check("R7 code 0", 8'b1111_1110);
        drive(3'd7); #1; check("R7 code 7", 8'b0111_1111);
        // R4: capture code 5, then raise hold and change inputs
        drive(3'd5); tick();
        hold = 1; drive(3'd2); #1;
        check("R4 held value from last transparent edge", model(3'd5, 0, 1));
        tick(); drive(3'd6); tick();
        check("R4 inputs ignored while holding", model(3'd5, 0, 1));
        // R5: disable, stay holding, change inputs, re-enable
        gate_n = 1; tick(); #1;
        check("R5 disabled while holding", 8'hFF);
        drive(3'd1); gate = 0; tick(); gate_n = 0; gate = 1; #1;
        check("R5 re-enable shows stored code", model(3'd5, 0, 1));
        // R5: register keeps following while gated off
        gate = 0; hold = 0; drive(3'd3); tick(); hold = 1; drive(3'd4); tick();
        gate = 1; #1;
        check("R5 capture proceeds while gated", model(3'd3, 0, 1));
        // R3: release hold -> live again
        hold = 0; #1;
        check("R3 release to live", model(3'd4, 0, 1));
        // R6: reset clears stored code
        drive(3'd6); tick();
        rst_n = 0; tick(); hold = 1; rst_n = 1; tick();
        check("R6 reset clears stored code", model(3'd0, 0, 1));
        hold = 0; #1;
        check("R3 live after reset", model(3'd6, 0, 1));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule